// File: doc/BRIEF.md
# Flash Rewrite-Mode Control Register

This block sits between a simple processor bus and the control side of an embedded flash array. It holds the bits that software uses to put the flash into rewrite mode, where erase and program commands are issued by software. It also holds the reset for the flash control circuit, the choice between the boot and user code areas, and the choice between two flash areas. Software cannot enter rewrite mode with a single stray store. It must first write the rewrite bit as 0 to the control register, and its next write to that register must set the bit to 1. The reset bit can only be raised while rewrite mode is on.

When rewrite mode is on, 8-bit commands written to even addresses inside the flash window are passed to the flash engine as one-cycle strobes, and direct array access is reported as not allowed. Changing the area-select bit holds off all access to the flash for a fixed number of clock cycles, so that the array can settle before the new area is used.

Top module: `flash_rewrite_ctl`

## Requirements
- R1: After reset, rewrite mode, the flash reset, the user-area bit and the area select are all 0, no command strobe is pending, access_ok is 1, and a control-register read returns 0x0001 while the engine is idle.
- R2: Bit 0 of a control-register read is the ready flag: 0 when flash_busy is 1 at the read, and 1 otherwise. Writes to this bit have no effect.
- R3: Rewrite mode (control bit 1) becomes 1 only on a control write with bit 1 = 1 whose previous control-register write had bit 1 = 0. Writes to other addresses in between do not break the pairing. A control write of 1 without that preceding 0 leaves the mode off.
- R4: A control write with bit 1 = 0 turns rewrite mode off at once, whatever the earlier history.
- R5: A control write with bit 3 = 1 raises flash_rst only if rewrite mode was already on before that write. flash_rst then stays 1 until a control write with bit 3 = 0.
- R6: user_region is 1 when boot_strap is 0. When boot_strap is 1, user_region follows control bit 5.
- R7: While rewrite mode is on, a write to the flash window (address MSB = 1) at an even address (address bit 0 = 0) gives cmd_valid = 1 for one cycle, starting the cycle after the write, with cmd_code equal to write-data bits 7:0. Odd-address writes, and all writes while rewrite mode is off, produce no strobe.
- R8: access_ok is 0 whenever rewrite mode is on.
- R9: A write to the area register that changes bit 1 updates area_sel and holds access_ok at 0 for exactly SETTLE_CYC (50) cycles. A write of the same value does not restart the wait.
- R10: Flash-window writes during the settling wait produce no command strobe.
- R11: A read of the area register returns area_sel in bit 1 and 0 in all other bits. Read data appears the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| flash_busy | input | 1 | Flash engine is programming or erasing |
| boot_strap | input | 1 | Device was started in boot mode |
| rd_data | output | 16 | Registered read data |
| cmd_valid | output | 1 | One-cycle command strobe to the flash engine |
| cmd_code | output | 8 | Command byte |
| flash_rst | output | 1 | Reset level for the flash control circuit |
| area_sel | output | 1 | Selected flash area |
| user_region | output | 1 | Code area in use is the user area |
| access_ok | output | 1 | Flash may be accessed directly |

## Verification
The bench targets the entry pairing. It checks a lone 1 after reset, a 0 and then a 1 separated by area-register traffic, and a second 1 written while already in the mode. A tracker that disarmed on foreign writes, or armed on reset, would give the wrong mode. It sets bit 3 while the mode is off and while it is on, to catch a reset that ignores the mode gate. It counts the settling window cycle by cycle, and writes an unchanged area value, to catch an off-by-one count or a restart on every write. Odd command addresses and commands issued during settling must not produce a strobe. Random traffic is checked against a bench model of all of these rules.

// File: rtl/flash_rewrite_pkg.sv
// Shared constants for the flash rewrite-mode control block.
// Assumes a 16-bit bus and byte addressing.
package flash_rewrite_pkg;
    localparam int DATA_W   = 16;
    localparam int CMD_W    = 8;
    // Control register bit positions (software-visible layout)
    localparam int RDY_BIT  = 0;
    localparam int RWM_BIT  = 1;
    localparam int FRST_BIT = 3;
    localparam int USR_BIT  = 5;
    // Area register bit position
    localparam int AREA_BIT = 1;
endpackage

// File: rtl/rwm_seq.sv
// Control register core: rewrite-mode entry guard, flash reset bit and user-area bit.
// Assumes wr_ctrl is a single-cycle qualified write to the control register.
module rwm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wd_rwm,
    input  logic wd_frst,
    input  logic wd_usr,
    output logic rewrite_on,
    output logic flash_rst,
    output logic user_bit
);
    logic armed_q;

    // Purpose: track the 0-then-1 entry sequence and update the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            rewrite_on <= 1'b0;
            flash_rst  <= 1'b0;
            user_bit   <= 1'b0;
        end else if (wr_ctrl) begin
            armed_q  <= ~wd_rwm;
            user_bit <= wd_usr;
            if (!wd_rwm) begin
                rewrite_on <= 1'b0;
            end else if (armed_q) begin
                rewrite_on <= 1'b1;
            end
            if (!wd_frst) begin
                flash_rst <= 1'b0;
            end else if (rewrite_on) begin
                flash_rst <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/area_settle.sv
// Area-select register with a settling counter that blocks access after a change.
// Assumes wr_area is a single-cycle qualified write to the area register.
module area_settle #(
    parameter int SETTLE_CYC = 50,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_area,
    input  logic sel_in,
    output logic area_sel,
    output logic settled
);
    logic [CNT_W-1:0] wait_q;

    // Purpose: load the wait on a real change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_sel <= 1'b0;
            wait_q   <= '0;
        end else if (wr_area && (sel_in != area_sel)) begin
            area_sel <= sel_in;
            wait_q   <= CNT_W'(SETTLE_CYC);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    // Purpose: report the end of the settling window.
    always_comb settled = (wait_q == '0);
endmodule

// File: rtl/cmd_gate.sv
// Command qualifier: passes even-address flash-window writes as a one-cycle strobe.
// Assumes enable already combines rewrite mode and the settled state.
module cmd_gate #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             in_window,
    input  logic             addr_lsb,
    input  logic             enable,
    input  logic [CMD_W-1:0] data,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_code
);
    // Purpose: register the strobe and capture the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_valid <= wr && in_window && !addr_lsb && enable;
            if (wr && in_window && !addr_lsb && enable) begin
                cmd_code <= data;
            end
        end
    end
endmodule

// File: rtl/flash_rewrite_ctl.sv
// Top of the flash rewrite-mode control block: address decode, register read-back,
// and the access gating outputs. Assumes one bus operation per cycle at most.
module flash_rewrite_ctl #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] CTRL_ADDR  = 16'h0040,
    parameter logic [15:0] AREA_ADDR  = 16'h0042,
    parameter int          SETTLE_CYC = 50
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [flash_rewrite_pkg::DATA_W-1:0] bus_wdata,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic                                flash_busy,
    input  logic                                boot_strap,
    output logic [flash_rewrite_pkg::DATA_W-1:0] rd_data,
    output logic                                cmd_valid,
    output logic [flash_rewrite_pkg::CMD_W-1:0]  cmd_code,
    output logic                                flash_rst,
    output logic                                area_sel,
    output logic                                user_region,
    output logic                                access_ok
);
    import flash_rewrite_pkg::*;

    logic hit_ctrl, hit_area, in_window;
    logic rewrite_on, user_bit, settled;
    logic [DATA_W-1:0] ctrl_view, area_view;
    logic unused_wdata;

    // Purpose: decode register and flash-window addresses.
    always_comb begin
        hit_ctrl  = (bus_addr == ADDR_W'(CTRL_ADDR));
        hit_area  = (bus_addr == ADDR_W'(AREA_ADDR));
        in_window = bus_addr[ADDR_W-1];
    end

    assign unused_wdata = ^bus_wdata;

    rwm_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (bus_wr && hit_ctrl),
        .wd_rwm     (bus_wdata[RWM_BIT]),
        .wd_frst    (bus_wdata[FRST_BIT]),
        .wd_usr     (bus_wdata[USR_BIT]),
        .rewrite_on (rewrite_on),
        .flash_rst  (flash_rst),
        .user_bit   (user_bit)
    );

    area_settle #(.SETTLE_CYC(SETTLE_CYC)) u_area (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_area  (bus_wr && hit_area),
        .sel_in   (bus_wdata[AREA_BIT]),
        .area_sel (area_sel),
        .settled  (settled)
    );

    cmd_gate #(.CMD_W(CMD_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .in_window (in_window),
        .addr_lsb  (bus_addr[0]),
        .enable    (rewrite_on && settled),
        .data      (bus_wdata[CMD_W-1:0]),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code)
    );

    // Purpose: assemble the software view of both registers.
    always_comb begin
        ctrl_view           = '0;
        ctrl_view[RDY_BIT]  = ~flash_busy;
        ctrl_view[RWM_BIT]  = rewrite_on;
        ctrl_view[FRST_BIT] = flash_rst;
        ctrl_view[USR_BIT]  = user_bit;
        area_view           = '0;
        area_view[AREA_BIT] = area_sel;
    end

    // Purpose: register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (bus_rd) begin
            rd_data <= hit_ctrl ? ctrl_view : (hit_area ? area_view : '0);
        end
    end

    // Purpose: derive code-area choice and direct-access permission.
    always_comb begin
        user_region = !boot_strap || user_bit;
        access_ok   = !rewrite_on && settled;
    end
endmodule

// File: rtl/flash_rewrite_chk.sv
// Assertion checker for flash_rewrite_ctl, bound to every instance.
// Assumes the same parameters as the top it is attached to.
module flash_rewrite_chk #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] CTRL_ADDR  = 16'h0040,
    parameter int          SETTLE_CYC = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              rewrite_on,
    input logic              flash_rst,
    input logic              area_sel,
    input logic              access_ok,
    input logic              cmd_valid
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    logic [CW-1:0] win_q;
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    // Purpose: independent count of cycles left after an area change.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else if (area_sel != $past(area_sel)) win_q <= CW'(SETTLE_CYC - 1);
        else if (win_q != '0) win_q <= win_q - 1'b1;
    end

    a_r3_entry_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rewrite_on) |-> $past(ctrl_wr && bus_wdata[1]));
    a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[1]) |=> !rewrite_on);
    a_r5_rst_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_rst) |-> $past(rewrite_on));
    a_r7_odd_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |=> !cmd_valid);
    a_r8_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rewrite_on |-> !access_ok);
    a_r9_change_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(area_sel) |-> !access_ok);
    a_r9_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != '0) |-> !access_ok);
endmodule

bind flash_rewrite_ctl flash_rewrite_chk #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rewrite_on(rewrite_on), .flash_rst(flash_rst),
    .area_sel(area_sel), .access_ok(access_ok), .cmd_valid(cmd_valid)
);

// File: tb/sim_flash_rewrite_ctl.sv
`timescale 1ns/1ps
module sim_flash_rewrite_ctl;
    localparam logic [15:0] CTRL = 16'h0040;
    localparam logic [15:0] AREA = 16'h0042;
    localparam int SETTLE = 50;

    logic clk = 0, rst_n = 0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic bus_wr = 0, bus_rd = 0, flash_busy = 0, boot_strap = 0;
    logic [15:0] rd_data;
    logic cmd_valid, flash_rst, area_sel, user_region, access_ok;
    logic [7:0] cmd_code;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    flash_rewrite_ctl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .flash_busy(flash_busy),
        .boot_strap(boot_strap), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .flash_rst(flash_rst), .area_sel(area_sel),
        .user_region(user_region), .access_ok(access_ok)
    );

    // Bench model built from the requirements.
    logic m_rw, m_arm, m_rst, m_usr, m_area, m_cv;
    logic [7:0] m_code;
    logic [15:0] m_rd;
    int m_cnt;

    function automatic logic [15:0] ctrl_img(logic busy, logic rw, logic rs, logic us);
        return {10'b0, us, 1'b0, rs, 1'b0, rw, ~busy};
    endfunction

    always @(posedge clk) begin
        logic o_rw;
        int o_cnt;
        o_rw = m_rw; o_cnt = m_cnt;
        if (!rst_n) begin
            m_rw = 0; m_arm = 0; m_rst = 0; m_usr = 0; m_area = 0;
            m_cnt = 0; m_cv = 0; m_code = 0; m_rd = 0;
        end else begin
            m_cv = bus_wr && bus_addr[15] && !bus_addr[0] && o_rw && (o_cnt == 0);
            if (m_cv) m_code = bus_wdata[7:0];
            if (bus_rd)
                m_rd = (bus_addr == CTRL) ? ctrl_img(flash_busy, m_rw, m_rst, m_usr) :
                       (bus_addr == AREA) ? {14'b0, m_area, 1'b0} : 16'h0;
            if (bus_wr && bus_addr == CTRL) begin
                if (!bus_wdata[1]) m_rw = 0; else if (m_arm) m_rw = 1;
                m_arm = !bus_wdata[1];
                if (!bus_wdata[3]) m_rst = 0; else if (o_rw) m_rst = 1;
                m_usr = bus_wdata[5];
            end
            if (bus_wr && bus_addr == AREA && bus_wdata[1] != m_area) begin
                m_area = bus_wdata[1]; m_cnt = SETTLE;
            end else if (m_cnt > 0) m_cnt = m_cnt - 1;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [15:0] a);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic check_model();
        chk("R5 flash_rst", {15'b0, flash_rst}, {15'b0, m_rst});
        chk("R8 access_ok", {15'b0, access_ok}, {15'b0, !m_rw && m_cnt == 0});
        chk("R9 area_sel", {15'b0, area_sel}, {15'b0, m_area});
        chk("R7 cmd_valid", {15'b0, cmd_valid}, {15'b0, m_cv});
        if (m_cv) chk("R7 cmd_code", {8'b0, cmd_code}, {8'b0, m_code});
        chk("R6 user_region", {15'b0, user_region}, {15'b0, !boot_strap || m_usr});
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1f2e;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(CTRL);
        chk("R1 ctrl read", rd_data, 16'h0001);
        chk("R1 access_ok", {15'b0, access_ok}, 16'h1);
        chk("R1 flash_rst/area/cmd", {13'b0, flash_rst, area_sel, cmd_valid}, 16'h0);
        // R2 ready flag
        flash_busy = 1; rd(CTRL);
        chk("R2 busy read", rd_data, 16'h0000);
        flash_busy = 0;
        // R3 lone 1 ignored
        wr(CTRL, 16'h0002);
        chk("R3 lone one", {15'b0, access_ok}, 16'h1);
        rd(CTRL); chk("R3 lone one bit1", rd_data, 16'h0001);
        // R5 reset bit outside mode has no effect
        wr(CTRL, 16'h0008);
        chk("R5 rst outside mode", {15'b0, flash_rst}, 16'h0);
        // R3 0 then 1 with foreign write between
        wr(CTRL, 16'h0000); wr(AREA, 16'h0000); wr(CTRL, 16'h0002);
        chk("R3 entry", {15'b0, access_ok}, 16'h0);
        rd(CTRL); chk("R3 entry bit1", rd_data, 16'h0003);
        wr(CTRL, 16'h0002);
        rd(CTRL); chk("R3 second one keeps mode", rd_data, 16'h0003);
        // R5 reset bit in mode
        wr(CTRL, 16'h000A);
        chk("R5 rst set", {15'b0, flash_rst}, 16'h1);
        wr(CTRL, 16'h0002);
        chk("R5 rst cleared", {15'b0, flash_rst}, 16'h0);
        // R7 commands
        wr(16'h8000, 16'h12A5);
        chk("R7 even strobe", {15'b0, cmd_valid}, 16'h1);
        chk("R7 code", {8'b0, cmd_code}, 16'h00A5);
        @(negedge clk);
        chk("R7 single cycle", {15'b0, cmd_valid}, 16'h0);
        wr(16'h8003, 16'h0055);
        chk("R7 odd discarded", {15'b0, cmd_valid}, 16'h0);
        // R10 command during settle
        wr(AREA, 16'h0002);
        wr(16'h8004, 16'h0033);
        chk("R10 settle refuses cmd", {15'b0, cmd_valid}, 16'h0);
        repeat (SETTLE) @(negedge clk);
        wr(16'h8004, 16'h0033);
        chk("R10 after settle", {15'b0, cmd_valid}, 16'h1);
        // R4 clear
        wr(CTRL, 16'h0000);
        chk("R4 cleared", {15'b0, access_ok}, 16'h1);
        wr(16'h8000, 16'h0011);
        chk("R7 no cmd outside mode", {15'b0, cmd_valid}, 16'h0);
        // R9 settle window length
        wr(AREA, 16'h0000);
        chk("R9 area_sel", {15'b0, area_sel}, 16'h0);
        chk("R9 blocked", {15'b0, access_ok}, 16'h0);
        repeat (SETTLE - 1) @(negedge clk);
        chk("R9 last blocked cycle", {15'b0, access_ok}, 16'h0);
        @(negedge clk);
        chk("R9 released", {15'b0, access_ok}, 16'h1);
        wr(AREA, 16'h0000);
        chk("R9 same value no restart", {15'b0, access_ok}, 16'h1);
        // R11 area read
        wr(AREA, 16'h0002); rd(AREA);
        chk("R11 area read", rd_data, 16'h0002);
        // R6 area selection
        boot_strap = 1; wr(CTRL, 16'h0000);
        chk("R6 boot mode boot area", {15'b0, user_region}, 16'h0);
        wr(CTRL, 16'h0020);
        chk("R6 boot mode user area", {15'b0, user_region}, 16'h1);
        wr(CTRL, 16'h0000); boot_strap = 0; #1;
        chk("R6 user boot forces user", {15'b0, user_region}, 16'h1);
        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 5);
            flash_busy = 1'($urandom);
            boot_strap = 1'($urandom);
            case (op)
                0, 1: wr(CTRL, 16'($urandom) & 16'h002A);
                2: wr(AREA, ($urandom_range(0, 7) == 0) ? 16'h0002 ^ {14'b0, m_area, 1'b0}
                                                     : {14'b0, m_area, 1'b0});
                3: wr(16'h8000 | 16'($urandom_range(0, 255)), 16'($urandom));
                4: begin
                    rd(($urandom_range(0, 1) == 0) ? CTRL : AREA);
                    chk("R2 R11 random read", rd_data, m_rd);
                end
                default: repeat ($urandom_range(1, 4)) @(negedge clk);
            endcase
            #1 check_model();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule